// File: doc/BRIEF.md
# Line Driver Fault Supervisor

This block supervises a single line driver. It detects two kinds of fault and controls the driver enable in response.

- **Short circuit.** A short is recognised when an overcurrent flag, already synchronized to the clock, stays high without a break for a qualification time. The driver is then forced off a fixed shutdown time after the flag first rose. This time is counted from the start of the overcurrent, not from qualification. From then on the block runs autoretry: the driver is switched back on for short test windows, one window per retry period. The block returns to normal control as soon as a window closes with the overcurrent flag low.
- **Voltage level.** This fault is reported while three things hold together: the driver is configured for open-drain operation, it is commanded off, and the line sits between the low and high receive thresholds. It does not start autoretry. The driver is already off whenever this condition holds.

Either fault drives a live fault bit and a sticky interrupt bit. The interrupt bit drives an active-low interrupt request. The sticky bit is released only by a status-read strobe.

All times are counted in clock cycles through parameters. The two threshold comparator inputs are asynchronous, so each passes through a two-flop synchronizer before it is used.

Top module: `drv_fault_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to normal control: `fault_live`=0, `fault_irq`=0, `irq_n`=1, and `drv_en` equals `drv_cmd`.
- R2: A short qualifies at the clock edge that samples `oc_flag`=1 for the `QUAL_CYC`-th consecutive time. A single low sample restarts the count from zero.
- R3: When a short qualifies, or the level condition becomes true, `fault_live` and `fault_irq` read 1 and `irq_n` reads 0 after that same edge.
- R4: `drv_en` is forced to 0 after the `SHUT_CYC`-th edge that counts from the first of the consecutive high `oc_flag` samples. Before that edge, `drv_en` follows `drv_cmd`.
- R5: After a shutdown, `drv_en` stays 0 for `PERIOD_CYC-WIN_CYC` cycles. It is then 1 for a `WIN_CYC`-cycle retry window, whatever the value of `drv_cmd`.
- R6: If `oc_flag` is 1 at the last edge of a retry window, the off and window sequence repeats, so windows start every `PERIOD_CYC` cycles.
- R7: If `oc_flag` is 0 at the last edge of a retry window, the block returns to normal control. `fault_live` then clears, while `fault_irq` stays 1.
- R8: The level fault holds `fault_live`=1 while `od_mode`=1, `drv_cmd`=0, the synchronized `line_above_lo`=1 and the synchronized `line_above_hi`=0. It clears one edge after the condition ends and never starts the off or retry sequence.
- R9: `fault_irq` (and `irq_n`=0) stays set until an edge with `status_rd`=1. A new fault event at that same edge keeps it set.
- R10: Each comparator input reaches the level logic through two flops. A comparator change is therefore seen in `fault_live` three edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oc_flag | input | 1 | Synchronized overcurrent flag from the driver's current limit |
| line_above_lo | input | 1 | Asynchronous: line is above the low receive threshold |
| line_above_hi | input | 1 | Asynchronous: line is above the high receive threshold |
| od_mode | input | 1 | Driver is configured for open-drain operation |
| drv_cmd | input | 1 | Driver on/off command |
| status_rd | input | 1 | Status-read strobe that releases the interrupt bit |
| drv_en | output | 1 | Driver enable |
| fault_live | output | 1 | A fault is present now |
| fault_irq | output | 1 | Sticky fault-interrupt bit |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The short controller's state is only visible through `drv_en` and `fault_live`. A miscount of any timer therefore shows up as a shutdown edge, a window edge or a window length landing one or more cycles away from where it should. A reference model compares every clock, so such a slip is reported on the first cycle the edge is misplaced. A wrong synchronizer depth shifts the level fault by a cycle and is caught at once. A sticky bit that clears wrongly is caught on the very next cycle after the offending edge.

// File: rtl/fs_pkg.sv
`timescale 1ns/1ps
// fs_pkg: shared types for the line driver fault supervisor.
// Assumes: nothing beyond the standard language.
package fs_pkg;
    // Short-circuit controller phases.
    typedef enum logic [1:0] {
        SV_IDLE  = 2'd0,  // normal driver control, overcurrent being qualified
        SV_ARMED = 2'd1,  // short qualified, shutdown time not yet reached
        SV_OFF   = 2'd2,  // driver held off between retry windows
        SV_RETRY = 2'd3   // driver forced on to test the short
    } short_st_t;
endpackage

// File: rtl/fs_sync.sv
`timescale 1ns/1ps
// fs_sync: two-flop synchronizer, one chain per bit of a W-bit bus.
// Assumes: bits are independent single-bit levels (no bus coherency).
module fs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic meta_q;
            logic sync_q;
            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                end else begin
                    meta_q <= d[gi];
                    sync_q <= meta_q;
                end
            end
            assign q[gi] = sync_q;
        end
    endgenerate
endmodule

// File: rtl/fs_short_ctl.sv
`timescale 1ns/1ps
// fs_short_ctl: qualifies a persistent overcurrent, times the shutdown
// from the first high sample, then runs periodic retry windows.
// Assumes: oc is already synchronous; SHUT_CYC > QUAL_CYC >= 1,
// PERIOD_CYC > WIN_CYC >= 1. A single counter serves every phase.
module fs_short_ctl
    import fs_pkg::*;
#(
    parameter int QUAL_CYC   = 8000,
    parameter int SHUT_CYC   = 12000,
    parameter int WIN_CYC    = 17500,
    parameter int PERIOD_CYC = 1300000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      oc,
    output short_st_t st,
    output logic      qual_evt
);
    localparam int MAXC  = (SHUT_CYC > PERIOD_CYC) ? SHUT_CYC : PERIOD_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int OFF_CYC = PERIOD_CYC - WIN_CYC;
    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_CYC - 1);
    localparam logic [CNT_W-1:0] SHUT_LAST = CNT_W'(SHUT_CYC - 1);
    localparam logic [CNT_W-1:0] OFF_LAST  = CNT_W'(OFF_CYC - 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_CYC - 1);

    short_st_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next phase and counter value.
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q + 1'b1;
        qual_evt = 1'b0;
        unique case (st_q)
            SV_IDLE: begin
                if (!oc) begin
                    cnt_d = '0;
                end else if (cnt_q == QUAL_LAST) begin
                    st_d     = SV_ARMED;
                    qual_evt = 1'b1;
                end
            end
            SV_ARMED: begin
                if (cnt_q == SHUT_LAST) begin
                    st_d  = SV_OFF;
                    cnt_d = '0;
                end
            end
            SV_OFF: begin
                if (cnt_q == OFF_LAST) begin
                    st_d  = SV_RETRY;
                    cnt_d = '0;
                end
            end
            SV_RETRY: begin
                if (cnt_q == WIN_LAST) begin
                    st_d  = oc ? SV_OFF : SV_IDLE;
                    cnt_d = '0;
                end
            end
            default: begin
                st_d  = SV_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SV_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/fs_level_det.sv
`timescale 1ns/1ps
// fs_level_det: flags a line left between the receive thresholds while
// an open-drain driver is off.
// Assumes: lo_s/hi_s are already synchronized; od/cmd are synchronous.
module fs_level_det (
    input  logic clk,
    input  logic rst_n,
    input  logic od,
    input  logic cmd,
    input  logic lo_s,
    input  logic hi_s,
    output logic lvl_flt,
    output logic lvl_evt
);
    logic cond;

    // Fault condition from the current samples.
    always_comb begin
        cond    = od & ~cmd & lo_s & ~hi_s;
        lvl_evt = cond & ~lvl_flt;
    end

    // Registered level fault; follows the condition with one edge of delay.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_flt <= 1'b0;
        else        lvl_flt <= cond;
    end
endmodule

// File: rtl/fs_irq_latch.sv
`timescale 1ns/1ps
// fs_irq_latch: sticky interrupt bit; set has priority over clear.
// Assumes: set and clr are single-cycle synchronous strobes or levels.
module fs_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq_q
);
    // Hold, set or release the sticky bit.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq_q <= 1'b0;
        else if (set) irq_q <= 1'b1;
        else if (clr) irq_q <= 1'b0;
    end
endmodule

// File: rtl/drv_fault_supervisor.sv
`timescale 1ns/1ps
// drv_fault_supervisor: top of the line driver fault supervisor. Combines
// short-circuit control, level-fault detection and the sticky interrupt,
// and drives the driver enable.
// Assumes: oc_flag and the control inputs are synchronous to clk; the two
// comparator inputs are asynchronous. All times are in clock cycles.
module drv_fault_supervisor
    import fs_pkg::*;
#(
    parameter int QUAL_CYC   = 8000,
    parameter int SHUT_CYC   = 12000,
    parameter int WIN_CYC    = 17500,
    parameter int PERIOD_CYC = 1300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic line_above_lo,
    input  logic line_above_hi,
    input  logic od_mode,
    input  logic drv_cmd,
    input  logic status_rd,
    output logic drv_en,
    output logic fault_live,
    output logic fault_irq,
    output logic irq_n
);
    localparam int NCMP = 2;

    logic [NCMP-1:0] cmp_s;
    short_st_t       short_st;
    logic            qual_evt;
    logic            lvl_flt;
    logic            lvl_evt;

    fs_sync #(.W(NCMP)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({line_above_hi, line_above_lo}),
        .q     (cmp_s)
    );

    fs_short_ctl #(
        .QUAL_CYC   (QUAL_CYC),
        .SHUT_CYC   (SHUT_CYC),
        .WIN_CYC    (WIN_CYC),
        .PERIOD_CYC (PERIOD_CYC)
    ) u_short (
        .clk      (clk),
        .rst_n    (rst_n),
        .oc       (oc_flag),
        .st       (short_st),
        .qual_evt (qual_evt)
    );

    fs_level_det u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .od      (od_mode),
        .cmd     (drv_cmd),
        .lo_s    (cmp_s[0]),
        .hi_s    (cmp_s[1]),
        .lvl_flt (lvl_flt),
        .lvl_evt (lvl_evt)
    );

    fs_irq_latch u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (qual_evt | lvl_evt),
        .clr   (status_rd),
        .irq_q (fault_irq)
    );

    // Driver enable from the short controller phase and the command.
    always_comb begin
        unique case (short_st)
            SV_OFF:   drv_en = 1'b0;
            SV_RETRY: drv_en = 1'b1;
            default:  drv_en = drv_cmd;
        endcase
    end

    // Live fault and interrupt request outputs.
    always_comb begin
        fault_live = lvl_flt | (short_st != SV_IDLE);
        irq_n      = ~fault_irq;
    end
endmodule

// File: rtl/fs_checker.sv
`timescale 1ns/1ps
// fs_checker: temporal properties of the fault supervisor, bound to the top.
module fs_checker
    import fs_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      oc_flag,
    input logic      status_rd,
    input logic      drv_en,
    input logic      fault_live,
    input logic      fault_irq,
    input short_st_t short_st
);
    // R2: without an overcurrent sample, normal control cannot leave.
    a_r2_no_qual_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (short_st == SV_IDLE && !oc_flag) |=> short_st == SV_IDLE);

    // R3: a fault appearing is always accompanied by the interrupt bit.
    a_r3_live_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_live) |-> fault_irq);

    // R4: while held off between windows, the driver is disabled.
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        short_st == SV_OFF |-> !drv_en);

    // R5: during a retry window, the driver is enabled.
    a_r5_window_on: assert property (@(posedge clk) disable iff (!rst_n)
        short_st == SV_RETRY |-> drv_en);

    // R6: after a shutdown, the phase only advances to a retry window.
    a_r6_off_to_retry: assert property (@(posedge clk) disable iff (!rst_n)
        short_st == SV_OFF |=> (short_st == SV_OFF || short_st == SV_RETRY));

    // R9: the sticky bit survives every edge without a read.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_irq && !status_rd) |=> fault_irq);
endmodule

bind drv_fault_supervisor fs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_flag    (oc_flag),
    .status_rd  (status_rd),
    .drv_en     (drv_en),
    .fault_live (fault_live),
    .fault_irq  (fault_irq),
    .short_st   (short_st)
);

// File: tb/drv_fault_supervisor_tb.sv
`timescale 1ns/1ps
// drv_fault_supervisor_tb: behavioural reference model compared every clock.
module drv_fault_supervisor_tb;
    localparam int QUAL   = 16;
    localparam int SHUT   = 24;
    localparam int WIN    = 10;
    localparam int PERIOD = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_flag = 0, line_above_lo = 0, line_above_hi = 0;
    logic od_mode = 0, drv_cmd = 1, status_rd = 0;
    logic drv_en, fault_live, fault_irq, irq_n;

    int total = 0;
    int bad = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    drv_fault_supervisor #(
        .QUAL_CYC(QUAL), .SHUT_CYC(SHUT), .WIN_CYC(WIN), .PERIOD_CYC(PERIOD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag),
        .line_above_lo(line_above_lo), .line_above_hi(line_above_hi),
        .od_mode(od_mode), .drv_cmd(drv_cmd), .status_rd(status_rd),
        .drv_en(drv_en), .fault_live(fault_live), .fault_irq(fault_irq),
        .irq_n(irq_n)
    );

    // Reference model: mode 0 normal, 1 qualified, 2 off, 3 window.
    int   m_mode = 0;
    int   m_run  = 0;
    bit   m_lvl = 0, m_irq = 0;
    bit   lo_pipe[$] = '{0, 0};
    bit   hi_pipe[$] = '{0, 0};

    always @(posedge clk) begin
        bit lc, newq;
        if (!rst_n) begin
            m_mode = 0; m_run = 0; m_lvl = 0; m_irq = 0;
            lo_pipe = '{0, 0}; hi_pipe = '{0, 0};
        end else begin
            lc = od_mode && !drv_cmd && lo_pipe[0] && !hi_pipe[0];
            newq = 0;
            m_run++;
            if (m_mode == 0) begin
                if (!oc_flag) m_run = 0;
                else if (m_run == QUAL) begin m_mode = 1; newq = 1; end
            end else if (m_mode == 1) begin
                if (m_run == SHUT) begin m_mode = 2; m_run = 0; end
            end else if (m_mode == 2) begin
                if (m_run == PERIOD - WIN) begin m_mode = 3; m_run = 0; end
            end else begin
                if (m_run == WIN) begin m_mode = oc_flag ? 2 : 0; m_run = 0; end
            end
            if (newq || (lc && !m_lvl)) m_irq = 1;
            else if (status_rd)         m_irq = 0;
            m_lvl = lc;
            void'(lo_pipe.pop_front()); lo_pipe.push_back(line_above_lo);
            void'(hi_pipe.pop_front()); hi_pipe.push_back(line_above_hi);
        end
    end

    task automatic check(input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%b exp=%b t=%0t", phase, what, act, exp, $time);
        end
    endtask

    // Advance one cycle and compare all outputs with the model.
    task automatic tick();
        bit e_drv;
        @(negedge clk);
        e_drv = (m_mode == 2) ? 1'b0 : (m_mode == 3) ? 1'b1 : drv_cmd;
        check("drv_en", drv_en, e_drv);
        check("fault_live", fault_live, m_lvl || (m_mode != 0));
        check("fault_irq", fault_irq, m_irq);
        check("irq_n", irq_n, !m_irq);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state.
        ticks(3);
        rst_n = 1'b1;
        tick();
        check("R1 irq_n", irq_n, 1'b1);
        check("R1 fault_live", fault_live, 1'b0);
        check("R1 drv_en", drv_en, 1'b1);
        ticks(3);

        // R2: interrupted overcurrent bursts never qualify.
        phase = "R2";
        oc_flag = 1; ticks(QUAL - 1);
        oc_flag = 0; tick();
        oc_flag = 1; ticks(QUAL - 1);
        oc_flag = 0; ticks(4);
        check("R2 no fault", fault_live, 1'b0);

        // R3/R4: sustained short; shutdown counted from the first high sample.
        phase = "R4";
        oc_flag = 1;
        for (int k = 1; k <= SHUT; k++) begin
            tick();
            if (k == QUAL) begin
                phase = "R3";
                check("R3 live at qual", fault_live, 1'b1);
                check("R3 irq_n at qual", irq_n, 1'b0);
                phase = "R4";
            end
            if (k == SHUT - 1) check("R4 still on", drv_en, 1'b1);
            if (k == SHUT)     check("R4 off at shutdown", drv_en, 1'b0);
        end

        // R5: off time, then a forced-on window even with command off.
        phase = "R5";
        drv_cmd = 0;
        ticks(PERIOD - WIN);
        check("R5 window open", drv_en, 1'b1);
        ticks(WIN);

        // R6: short persists, so the sequence repeats.
        phase = "R6";
        ticks(PERIOD - WIN - 1);
        check("R6 still off", drv_en, 1'b0);
        tick();
        check("R6 second window", drv_en, 1'b1);
        ticks(WIN - 2);

        // R7: short gone before the window closes; normal control resumes.
        phase = "R7";
        oc_flag = 0; drv_cmd = 1;
        ticks(2);
        check("R7 live cleared", fault_live, 1'b0);
        check("R7 irq kept", fault_irq, 1'b1);
        ticks(5);

        // R9: read releases the sticky bit.
        phase = "R9";
        status_rd = 1; tick();
        status_rd = 0; tick();
        check("R9 released", irq_n, 1'b1);

        // R8: level fault, held well beyond the shutdown time; no retry.
        phase = "R8";
        drv_cmd = 0; od_mode = 1; line_above_lo = 1; line_above_hi = 0;
        ticks(SHUT + 20);
        check("R8 live", fault_live, 1'b1);
        check("R8 no retry", drv_en, 1'b0);
        line_above_hi = 1;
        ticks(4);
        check("R8 cleared", fault_live, 1'b0);
        status_rd = 1; tick(); status_rd = 0;

        // R10: comparator edge takes three edges to reach fault_live.
        phase = "R10";
        line_above_hi = 0;
        tick(); tick();
        check("R10 not yet", fault_live, 1'b0);
        tick();
        check("R10 seen", fault_live, 1'b1);
        line_above_lo = 0; ticks(4);
        line_above_lo = 1; tick(); line_above_lo = 0; ticks(5);

        // R9: read held across a new level event; the set wins at that edge.
        phase = "R9";
        status_rd = 1;
        ticks(2);
        line_above_lo = 1; ticks(6);
        status_rd = 0;
        od_mode = 0; ticks(4);
        line_above_lo = 0; drv_cmd = 1; ticks(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule